// File: doc/BRIEF.md
# I2C Master Command and Acknowledge Controller

This block is the control path of an I2C master. Software writes a small control register whose low two bits are a command strobe and whose bit 2 chooses the acknowledge to send after a received byte. The block turns each accepted command into a one-cycle request to a byte engine: repeated START, read the next byte, STOP, or a bare acknowledge. In read mode it attaches the pending ACK or NACK to that request. It raises a read flag and a write flag when the engine reports an address or byte phase. It also tracks how long both bus lines have been high and reports an idle bus after a selectable time.

Two options change when things happen. Smart mode lets a read of the receive data register release the acknowledge at once, with no command write. Quick mode raises a flag as soon as the slave acknowledges the address. Software can then close the transfer with STOP or restart it.

Top module: `i2c_master_cmd_ctl`

## Requirements
- R1: After reset, reqValid, rdFlag, wrFlag, cmdErr and busIdle are 0 and regRdata reads 0.
- R2: regRdata returns the stored acknowledge bit at bit 2. Bits 7:3 and the command bits 1:0 always read 0, whatever was written.
- R3: In read mode a command of 01, 10 or 11 produces, in the cycle after the write, a request with reqOp 1 (repeated START), 2 (read byte) or 3 (STOP). If a received byte is still unacknowledged, the request carries reqAckEn=1 and reqNack equal to the acknowledge bit written with the command (0 = ACK, 1 = NACK).
- R4: In write mode, command 01 requests repeated START and 11 requests STOP, both with reqAckEn=0. Command 10 produces no request and no error.
- R5: With smart mode on and a received byte unacknowledged, a data-register read issues a request in the next cycle with reqAckEn=1. reqOp is 2 when the stored bit selects ACK and 4 (acknowledge only) when it selects NACK. The read also clears rdFlag. With smart mode off, a data-register read issues nothing and leaves rdFlag set.
- R6: Each received byte is acknowledged once. After a smart-mode acknowledge, the next command carries reqAckEn=0.
- R7: A completed byte sets rdFlag in read mode and wrFlag in write mode. An acknowledged write-direction address sets wrFlag. An acknowledged read-direction address sets no flag while quick mode is off.
- R8: With quick mode on, an acknowledged read-direction address sets rdFlag.
- R9: Issuing a command clears both flags.
- R10: A nonzero command, or a smart-mode acknowledge, that arrives while reqReady is low or a request is being presented is dropped. It sets cmdErr, which stays set until reset.
- R11: busIdle rises once SCL and SDA have both been high for 50, 100 or 200 microseconds, for cfgTimeout 01, 10 or 11. It is 0 while either line is low and whenever cfgTimeout is 00.
- R12: reqValid is never high in two consecutive cycles.
- R13: A command write and a smart-mode data read in the same cycle produce a single request, from the command, carrying the pending acknowledge once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Control register write strobe |
| regWdata | input | 8 | Write data: bit 2 acknowledge choice, bits 1:0 command |
| regRdata | output | 8 | Control register read value |
| cfgSmart | input | 1 | Smart mode enable |
| cfgQuick | input | 1 | Quick command enable |
| cfgTimeout | input | 2 | Idle-bus time select |
| dataRd | input | 1 | Receive data register read strobe |
| reqValid | output | 1 | One-cycle request to the byte engine |
| reqOp | output | 3 | Requested operation |
| reqAckEn | output | 1 | Send an acknowledge before the operation |
| reqNack | output | 1 | Acknowledge level: 1 = NACK |
| reqReady | input | 1 | Byte engine can accept a request |
| engDone | input | 1 | Engine finished a phase |
| engAddr | input | 1 | Finished phase was an acknowledged address |
| engRx | input | 1 | Address direction was read |
| rdFlag | output | 1 | Read interrupt flag |
| wrFlag | output | 1 | Write interrupt flag |
| cmdErr | output | 1 | Sticky dropped-command flag |
| scl | input | 1 | Sampled clock line |
| sda | input | 1 | Sampled data line |
| busIdle | output | 1 | Bus idle for the selected time |

## Verification
A command write and a smart-mode data read can land in the same clock cycle. Each would otherwise issue its own acknowledge. The bench drives regWr and dataRd together while a received byte awaits its acknowledge, with a stored NACK and an ACK in the written data. It expects exactly one repeated-START request carrying an ACK and a cleared read flag. The scoreboard treats any second request in the following cycles as a failure.

// File: rtl/i2c_mst_pkg.sv
package i2c_mst_pkg;

  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_RSTART  = 3'd1,
    OP_READ    = 3'd2,
    OP_STOP    = 3'd3,
    OP_ACKONLY = 3'd4
  } busOp_e;

  localparam logic [1:0] CMD_NOP    = 2'b00;
  localparam logic [1:0] CMD_RSTART = 2'b01;
  localparam logic [1:0] CMD_BYTE   = 2'b10;
  localparam logic [1:0] CMD_STOP   = 2'b11;

  localparam int ACK_BIT = 2;

  typedef struct packed {
    logic   issue;
    busOp_e op;
    logic   ackEn;
    logic   nack;
    logic   setErr;
    logic   clrRd;
    logic   clrWr;
  } ctlStrobe_t;

endpackage

// File: rtl/i2c_mst_ctl.sv
module i2c_mst_ctl
  import i2c_mst_pkg::*;
(
  input  logic       regWr,
  input  logic [1:0] cmd,
  input  logic       ackNew,
  input  logic       ackStored,
  input  logic       dataRd,
  input  logic       cfgSmart,
  input  logic       busy,
  input  logic       readMode,
  input  logic       ackPending,
  output ctlStrobe_t st
);

  logic cmdAct;
  logic smartAct;

  assign cmdAct   = regWr && (cmd != CMD_NOP);
  assign smartAct = dataRd && cfgSmart && ackPending;

  always_comb begin
    st = '0;
    st.op = OP_NONE;
    if (cmdAct) begin
      if (busy) begin
        st.setErr = 1'b1;
      end else if (readMode) begin
        st.issue = 1'b1;
        st.ackEn = ackPending;
        st.nack  = ackNew;
        case (cmd)
          CMD_RSTART: st.op = OP_RSTART;
          CMD_BYTE:   st.op = OP_READ;
          default:    st.op = OP_STOP;
        endcase
      end else begin
        case (cmd)
          CMD_RSTART: begin st.issue = 1'b1; st.op = OP_RSTART; end
          CMD_STOP:   begin st.issue = 1'b1; st.op = OP_STOP; end
          default:    st.issue = 1'b0;
        endcase
      end
    end else if (smartAct) begin
      if (busy) begin
        st.setErr = 1'b1;
      end else begin
        st.issue = 1'b1;
        st.ackEn = 1'b1;
        st.nack  = ackStored;
        st.op    = ackStored ? OP_ACKONLY : OP_READ;
      end
    end
    if (st.issue) begin
      st.clrRd = 1'b1;
      st.clrWr = 1'b1;
    end
    if (dataRd && cfgSmart) st.clrRd = 1'b1;
  end

endmodule

// File: rtl/i2c_idle_timer.sv
module i2c_idle_timer #(
  parameter int CLK_HZ     = 125_000_000,
  parameter int T_SHORT_US = 50,
  parameter int T_MID_US   = 100,
  parameter int T_LONG_US  = 200
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] sel,
  input  logic       scl,
  input  logic       sda,
  output logic       busIdle
);

  localparam int DIV = CLK_HZ / 1_000_000;
  localparam int PW  = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int CW  = $clog2(T_LONG_US + 1);

  logic [PW-1:0] psc;
  logic [CW-1:0] usCnt;
  logic [CW-1:0] lim;
  logic          enabled;
  logic          linesHigh;

  assign enabled   = (sel != 2'b00);
  assign linesHigh = scl && sda;

  always_comb begin
    case (sel)
      2'b01:   lim = CW'(T_SHORT_US);
      2'b10:   lim = CW'(T_MID_US);
      default: lim = CW'(T_LONG_US);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN || !enabled || !linesHigh) begin
      psc   <= '0;
      usCnt <= '0;
    end else if (psc == PW'(DIV - 1)) begin
      psc <= '0;
      if (usCnt != CW'(T_LONG_US)) usCnt <= usCnt + 1'b1;
    end else begin
      psc <= psc + 1'b1;
    end
  end

  assign busIdle = enabled && linesHigh && (usCnt >= lim);

endmodule

// File: rtl/i2c_mst_dp.sv
module i2c_mst_dp
  import i2c_mst_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrobe_t st,
  input  logic       regWr,
  input  logic       ackNew,
  input  logic       engDone,
  input  logic       engAddr,
  input  logic       engRx,
  input  logic       cfgQuick,
  output logic       ackStored,
  output logic       readMode,
  output logic       ackPending,
  output logic       reqValid,
  output busOp_e     reqOp,
  output logic       reqAckEn,
  output logic       reqNack,
  output logic       rdFlag,
  output logic       wrFlag,
  output logic       cmdErr
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ackStored  <= 1'b0;
      readMode   <= 1'b0;
      ackPending <= 1'b0;
      reqValid   <= 1'b0;
      reqOp      <= OP_NONE;
      reqAckEn   <= 1'b0;
      reqNack    <= 1'b0;
      rdFlag     <= 1'b0;
      wrFlag     <= 1'b0;
      cmdErr     <= 1'b0;
    end else begin
      if (regWr) ackStored <= ackNew;
      reqValid <= st.issue;
      if (st.issue) begin
        reqOp    <= st.op;
        reqAckEn <= st.ackEn;
        reqNack  <= st.nack;
      end
      if (st.setErr) cmdErr <= 1'b1;

      if (st.issue && st.ackEn) ackPending <= 1'b0;
      if (st.clrRd) rdFlag <= 1'b0;
      if (st.clrWr) wrFlag <= 1'b0;

      if (engDone) begin
        if (engAddr) begin
          readMode   <= engRx;
          ackPending <= 1'b0;
          if (!engRx)        wrFlag <= 1'b1;
          else if (cfgQuick) rdFlag <= 1'b1;
        end else if (readMode) begin
          ackPending <= 1'b1;
          rdFlag     <= 1'b1;
        end else begin
          wrFlag <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/i2c_master_cmd_ctl.sv
module i2c_master_cmd_ctl
  import i2c_mst_pkg::*;
#(
  parameter int CLK_HZ     = 125_000_000,
  parameter int T_SHORT_US = 50,
  parameter int T_MID_US   = 100,
  parameter int T_LONG_US  = 200
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWr,
  input  logic [7:0] regWdata,
  output logic [7:0] regRdata,
  input  logic       cfgSmart,
  input  logic       cfgQuick,
  input  logic [1:0] cfgTimeout,
  input  logic       dataRd,
  output logic       reqValid,
  output logic [2:0] reqOp,
  output logic       reqAckEn,
  output logic       reqNack,
  input  logic       reqReady,
  input  logic       engDone,
  input  logic       engAddr,
  input  logic       engRx,
  output logic       rdFlag,
  output logic       wrFlag,
  output logic       cmdErr,
  input  logic       scl,
  input  logic       sda,
  output logic       busIdle
);

  ctlStrobe_t st;
  busOp_e     opQ;
  logic       ackStored;
  logic       readMode;
  logic       ackPending;
  logic       busy;

  assign busy  = !reqReady || reqValid;
  assign reqOp = opQ;

  always_comb begin
    regRdata = '0;
    regRdata[ACK_BIT] = ackStored;
  end

  i2c_mst_ctl u_ctl (
    .regWr      (regWr),
    .cmd        (regWdata[1:0]),
    .ackNew     (regWdata[ACK_BIT]),
    .ackStored  (ackStored),
    .dataRd     (dataRd),
    .cfgSmart   (cfgSmart),
    .busy       (busy),
    .readMode   (readMode),
    .ackPending (ackPending),
    .st         (st)
  );

  i2c_mst_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .st         (st),
    .regWr      (regWr),
    .ackNew     (regWdata[ACK_BIT]),
    .engDone    (engDone),
    .engAddr    (engAddr),
    .engRx      (engRx),
    .cfgQuick   (cfgQuick),
    .ackStored  (ackStored),
    .readMode   (readMode),
    .ackPending (ackPending),
    .reqValid   (reqValid),
    .reqOp      (opQ),
    .reqAckEn   (reqAckEn),
    .reqNack    (reqNack),
    .rdFlag     (rdFlag),
    .wrFlag     (wrFlag),
    .cmdErr     (cmdErr)
  );

  i2c_idle_timer #(
    .CLK_HZ     (CLK_HZ),
    .T_SHORT_US (T_SHORT_US),
    .T_MID_US   (T_MID_US),
    .T_LONG_US  (T_LONG_US)
  ) u_timer (
    .clk     (clk),
    .rstN    (rstN),
    .sel     (cfgTimeout),
    .scl     (scl),
    .sda     (sda),
    .busIdle (busIdle)
  );

endmodule

// File: rtl/i2c_master_cmd_ctl_chk.sv
module i2c_master_cmd_ctl_chk
  import i2c_mst_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic [7:0] regRdata,
  input logic [1:0] cfgTimeout,
  input logic       reqValid,
  input logic [2:0] reqOp,
  input logic       reqAckEn,
  input logic       reqNack,
  input logic       reqReady,
  input logic       engDone,
  input logic       rdFlag,
  input logic       cmdErr,
  input logic       scl,
  input logic       sda,
  input logic       busIdle
);

  p_pulse_r12: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> !reqValid);

  p_ready_seen_r10: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> $past(reqReady));

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    cmdErr |=> cmdErr);

  p_ackonly_nack_r5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp == 3'(OP_ACKONLY)) |-> (reqAckEn && reqNack));

  p_issue_clears_rd_r9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !$past(engDone)) |-> !rdFlag);

  p_idle_lines_r11: assert property (@(posedge clk) disable iff (!rstN)
    busIdle |-> (scl && sda && cfgTimeout != 2'b00));

  p_idle_rise_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busIdle) |-> $past(scl && sda));

  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (regRdata[7:3] == 5'd0) && (regRdata[1:0] == 2'd0));

endmodule

bind i2c_master_cmd_ctl i2c_master_cmd_ctl_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .regRdata   (regRdata),
  .cfgTimeout (cfgTimeout),
  .reqValid   (reqValid),
  .reqOp      (reqOp),
  .reqAckEn   (reqAckEn),
  .reqNack    (reqNack),
  .reqReady   (reqReady),
  .engDone    (engDone),
  .rdFlag     (rdFlag),
  .cmdErr     (cmdErr),
  .scl        (scl),
  .sda        (sda),
  .busIdle    (busIdle)
);

// File: tb/i2c_master_cmd_ctl_tb.sv
module i2c_master_cmd_ctl_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWr = 1'b0;
  logic [7:0] regWdata = 8'h00;
  logic [7:0] regRdata;
  logic       cfgSmart = 1'b0;
  logic       cfgQuick = 1'b0;
  logic [1:0] cfgTimeout = 2'b00;
  logic       dataRd = 1'b0;
  logic       reqValid;
  logic [2:0] reqOp;
  logic       reqAckEn;
  logic       reqNack;
  logic       reqReady = 1'b1;
  logic       engDone = 1'b0;
  logic       engAddr = 1'b0;
  logic       engRx = 1'b0;
  logic       rdFlag;
  logic       wrFlag;
  logic       cmdErr;
  logic       scl = 1'b0;
  logic       sda = 1'b0;
  logic       busIdle;

  int errors = 0;
  int checks = 0;
  logic [4:0] expQ[$];
  logic prevValid = 1'b0;
  bit pulseBad = 1'b0;

  always #4 clk = ~clk;

  i2c_master_cmd_ctl u_dut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regWdata(regWdata),
    .regRdata(regRdata), .cfgSmart(cfgSmart), .cfgQuick(cfgQuick),
    .cfgTimeout(cfgTimeout), .dataRd(dataRd), .reqValid(reqValid),
    .reqOp(reqOp), .reqAckEn(reqAckEn), .reqNack(reqNack),
    .reqReady(reqReady), .engDone(engDone), .engAddr(engAddr),
    .engRx(engRx), .rdFlag(rdFlag), .wrFlag(wrFlag), .cmdErr(cmdErr),
    .scl(scl), .sda(sda), .busIdle(busIdle)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // monitor: pops expected requests as the design presents them
  always @(negedge clk) begin
    if (rstN) begin
      if (reqValid && prevValid) pulseBad = 1'b1;
      if (reqValid) begin
        if (expQ.size() == 0) begin
          chk(1'b0, "unexpected request (R4/R5/R10/R13)", int'({reqOp, reqAckEn, reqNack}), -1);
        end else begin
          logic [4:0] e;
          e = expQ.pop_front();
          chk({reqOp, reqAckEn, reqNack} == e, "request fields (R3/R4/R5/R6/R13)",
              int'({reqOp, reqAckEn, reqNack}), int'(e));
        end
      end
      prevValid = reqValid;
    end
  end

  task automatic expectReq(input logic [2:0] op, input logic ae, input logic nk);
    expQ.push_back({op, ae, nk});
  endtask

  task automatic regWrite(input logic [7:0] d, input logic rd);
    @(negedge clk);
    regWr = 1'b1; regWdata = d; dataRd = rd;
    @(negedge clk);
    regWr = 1'b0; dataRd = 1'b0;
  endtask

  task automatic readData();
    @(negedge clk);
    dataRd = 1'b1;
    @(negedge clk);
    dataRd = 1'b0;
  endtask

  task automatic engine(input logic isAddr, input logic rx);
    @(negedge clk);
    engDone = 1'b1; engAddr = isAddr; engRx = rx;
    @(negedge clk);
    engDone = 1'b0; engAddr = 1'b0; engRx = 1'b0;
  endtask

  task automatic drained(input string tag);
    repeat (3) @(negedge clk);
    chk(expQ.size() == 0, tag, expQ.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(reqValid == 0, "R1 reqValid", reqValid, 0);
    chk({rdFlag, wrFlag, cmdErr} == 0, "R1 flags", {rdFlag, wrFlag, cmdErr}, 0);
    chk(regRdata == 0, "R1 regRdata", regRdata, 0);
    chk(busIdle == 0, "R1 busIdle", busIdle, 0);

    // R2 readback; 0xFF in write mode is a STOP command (R4)
    expectReq(3'd3, 1'b0, 1'b0);
    regWrite(8'hFF, 1'b0);
    chk(regRdata == 8'h04, "R2 readback after 0xFF", regRdata, 8'h04);
    drained("R4 stop in write mode");
    regWrite(8'h00, 1'b0);
    chk(regRdata == 8'h00, "R2 readback after 0x00", regRdata, 0);

    // write direction
    engine(1'b1, 1'b0);
    chk(wrFlag == 1 && rdFlag == 0, "R7 write address sets wrFlag", {rdFlag, wrFlag}, 1);
    regWrite(8'h02, 1'b0);
    drained("R4 byte command ignored in write mode");
    chk(wrFlag == 1 && cmdErr == 0, "R4 no effect no error", {wrFlag, cmdErr}, 2);
    expectReq(3'd1, 1'b0, 1'b0);
    regWrite(8'h01, 1'b0);
    chk(wrFlag == 0, "R9 command clears wrFlag", wrFlag, 0);
    engine(1'b0, 1'b0);
    chk(wrFlag == 1, "R7 written byte sets wrFlag", wrFlag, 1);
    expectReq(3'd3, 1'b0, 1'b0);
    regWrite(8'h03, 1'b0);
    drained("R4 write-mode stop");

    // read direction, no quick
    engine(1'b1, 1'b1);
    chk({rdFlag, wrFlag} == 0, "R7 read address sets no flag", {rdFlag, wrFlag}, 0);
    engine(1'b0, 1'b0);
    chk(rdFlag == 1, "R7 received byte sets rdFlag", rdFlag, 1);
    expectReq(3'd2, 1'b1, 1'b0);
    regWrite(8'h02, 1'b0);
    chk(rdFlag == 0, "R9 command clears rdFlag", rdFlag, 0);
    engine(1'b0, 1'b0);
    expectReq(3'd1, 1'b1, 1'b0);
    regWrite(8'h01, 1'b0);
    engine(1'b0, 1'b0);
    expectReq(3'd3, 1'b1, 1'b1);
    regWrite(8'h07, 1'b0);
    drained("R3 read-mode commands");

    // smart mode
    cfgSmart = 1'b1;
    engine(1'b1, 1'b1);
    regWrite(8'h00, 1'b0);
    engine(1'b0, 1'b0);
    expectReq(3'd2, 1'b1, 1'b0);
    readData();
    chk(rdFlag == 0, "R5 smart read clears rdFlag", rdFlag, 0);
    engine(1'b0, 1'b0);
    regWrite(8'h04, 1'b0);
    expectReq(3'd4, 1'b1, 1'b1);
    readData();
    drained("R5 smart nack acknowledge only");
    readData();
    drained("R5 smart read without pending byte");
    expectReq(3'd3, 1'b0, 1'b1);
    regWrite(8'h07, 1'b0);
    drained("R6 command after smart ack carries no ack");

    // smart off: data read does nothing
    cfgSmart = 1'b0;
    engine(1'b1, 1'b1);
    engine(1'b0, 1'b0);
    readData();
    drained("R5 smart off no request");
    chk(rdFlag == 1, "R5 smart off keeps rdFlag", rdFlag, 1);
    expectReq(3'd2, 1'b1, 1'b0);
    regWrite(8'h02, 1'b0);
    drained("R3 ack carried after plain read");

    // R13 same-cycle command and smart read
    cfgSmart = 1'b1;
    regWrite(8'h04, 1'b0);
    engine(1'b0, 1'b0);
    expectReq(3'd1, 1'b1, 1'b0);
    regWrite(8'h01, 1'b1);
    chk(rdFlag == 0, "R13 rdFlag cleared", rdFlag, 0);
    drained("R13 single request");
    cfgSmart = 1'b0;

    // R8 quick command
    cfgQuick = 1'b1;
    engine(1'b1, 1'b1);
    chk(rdFlag == 1, "R8 quick read address sets rdFlag", rdFlag, 1);
    expectReq(3'd3, 1'b0, 1'b0);
    regWrite(8'h03, 1'b0);
    drained("R8 stop after quick address");
    cfgQuick = 1'b0;

    // R10 busy
    engine(1'b1, 1'b0);
    chk(cmdErr == 0, "R10 no error before busy", cmdErr, 0);
    reqReady = 1'b0;
    regWrite(8'h01, 1'b0);
    chk(cmdErr == 1, "R10 error when not ready", cmdErr, 1);
    reqReady = 1'b1;
    drained("R10 dropped while not ready");
    expectReq(3'd1, 1'b0, 1'b0);
    @(negedge clk);
    regWr = 1'b1; regWdata = 8'h01;
    @(negedge clk);
    regWdata = 8'h03;
    @(negedge clk);
    regWr = 1'b0;
    drained("R10 back-to-back second dropped");
    chk(cmdErr == 1, "R10 error sticky", cmdErr, 1);
    chk(!pulseBad, "R12 single-cycle request", pulseBad, 0);

    // R11 idle timer
    cfgTimeout = 2'b01;
    @(negedge clk);
    scl = 1'b1; sda = 1'b1;
    repeat (6200) @(negedge clk);
    chk(busIdle == 0, "R11 50us not yet", busIdle, 0);
    repeat (100) @(negedge clk);
    chk(busIdle == 1, "R11 50us reached", busIdle, 1);
    sda = 1'b0;
    #1;
    chk(busIdle == 0, "R11 line low clears", busIdle, 0);
    cfgTimeout = 2'b10;
    @(negedge clk);
    sda = 1'b1;
    repeat (12400) @(negedge clk);
    chk(busIdle == 0, "R11 100us not yet", busIdle, 0);
    repeat (200) @(negedge clk);
    chk(busIdle == 1, "R11 100us reached", busIdle, 1);
    cfgTimeout = 2'b11;
    #1;
    chk(busIdle == 0, "R11 200us select restarts wait", busIdle, 0);
    repeat (25100) @(negedge clk);
    chk(busIdle == 1, "R11 200us reached", busIdle, 1);
    cfgTimeout = 2'b00;
    #1;
    chk(busIdle == 0, "R11 disabled", busIdle, 0);

    summary();
    $finish;
  end

endmodule